// File: doc/BRIEF.md
# Exception Priority Arbiter and Vector Selector

This block collects every exception source that can be pending in the same cycle and picks exactly one to service. It returns an 8-bit vector number, a 2-bit group code and an abort flag, all registered. The sources are arranged in three timing classes.

The abort class (code 0) covers the reset request, bus error and address error. It is taken in any cycle and tells the sequencer to abandon the current instruction. The boundary class (code 1) covers trace, interrupt levels, illegal instruction, the A-line and F-line opcode traps and privilege violation. It is considered only in a cycle where the sequencer marks an instruction as complete. The instruction class (code 2) covers the conditions that the executing instruction raises itself: TRAP n, TRAPV, a CHK bounds failure and divide by zero. A fixed order applies inside each class.

The sequencer presents its sources for one cycle and reads the result one clock later. Masking of interrupts is left to the interrupt controller: any nonzero level presented here counts as pending.

Top module: `exc_arbiter`

## Requirements
- R1: The abort class is ordered reset request (vector 0), then bus error (vector 2), then address error (vector 3). It reports group code 0 and does not depend on instruction completion.
- R2: Boundary-class sources are ignored unless `insn_done_i` is 1 in the same cycle. When it is 1 the order is trace (vector 9), interrupt levels 7 down to 1 (vector 24 + level), illegal instruction (4), A-line (10), F-line (11), then privilege violation (8). Group code is 1.
- R3: Trace is raised only when `trace_en_i` is 1 at an instruction boundary.
- R4: When `opcode_vld_i` is 1, an opcode whose bits [15:12] are 4'hA raises the A-line source and one whose bits [15:12] are 4'hF raises the F-line source. No other value raises either.
- R5: Instruction-class sources need no boundary. They are ordered TRAP n (vector 32 + n, n = `trap_num_i`), TRAPV (7), CHK (6), then zero divide (5). Group code is 2.
- R6: TRAPV raises its exception only when `v_flag_i` is 1. Without the flag it is ignored.
- R7: CHK fails when the signed `chk_val_i` is below 0 or above the signed `chk_bound_i`. A value equal to the bound, or equal to 0, passes.
- R8: Across classes, the abort class outranks the boundary class, and the boundary class outranks the instruction class.
- R9: The outputs register the selection one clock after the inputs. `abort_o` is 1 only with group code 0. With no source selected, `valid_o`, `vector_o`, `group_o` and `abort_o` are all 0.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset exception request |
| bus_err_i | input | 1 | Bus error strobe |
| addr_err_i | input | 1 | Address error strobe |
| insn_done_i | input | 1 | Current instruction completes this cycle |
| trace_en_i | input | 1 | Trace mode bit |
| irq_lvl_i | input | 3 | Pending interrupt level, 0 = none |
| illegal_i | input | 1 | Illegal opcode flag |
| priv_viol_i | input | 1 | Privilege violation flag |
| opcode_vld_i | input | 1 | Opcode field is valid |
| opcode_i | input | 16 | Current opcode |
| trap_i | input | 1 | TRAP instruction executing |
| trap_num_i | input | 4 | TRAP number |
| trapv_i | input | 1 | TRAPV instruction executing |
| v_flag_i | input | 1 | Overflow flag |
| chk_i | input | 1 | CHK instruction executing |
| chk_val_i | input | 32 | Signed register operand of CHK |
| chk_bound_i | input | 32 | Signed upper bound of CHK |
| zdiv_i | input | 1 | Divide with zero divisor |
| valid_o | output | 1 | An exception is selected |
| vector_o | output | 8 | Selected vector number |
| group_o | output | 2 | Group code 0, 1 or 2 |
| abort_o | output | 1 | Abort current instruction |

## Verification
Every result is due exactly one clock after the input pattern that causes it, because the selection passes through a single register stage. The bench drives each pattern just after a falling edge and samples all four outputs at the next falling edge. By then the rising edge between the two has loaded the result. The reference model uses the pattern held across that rising edge, so each cycle's comparison pairs the inputs with their own result. Consecutive patterns can therefore change every cycle without the checks smearing across cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W   = 8;
  localparam int LVL_W   = 3;
  localparam int TRAP_W  = 4;

  typedef enum logic [1:0] {
    GRP_ABORT    = 2'd0,
    GRP_BOUNDARY = 2'd1,
    GRP_INSN     = 2'd2
  } exc_grp_e;

  localparam logic [VEC_W-1:0] VEC_RESET     = 8'd0;
  localparam logic [VEC_W-1:0] VEC_BUS_ERR   = 8'd2;
  localparam logic [VEC_W-1:0] VEC_ADDR_ERR  = 8'd3;
  localparam logic [VEC_W-1:0] VEC_ILLEGAL   = 8'd4;
  localparam logic [VEC_W-1:0] VEC_ZDIV      = 8'd5;
  localparam logic [VEC_W-1:0] VEC_CHK       = 8'd6;
  localparam logic [VEC_W-1:0] VEC_TRAPV     = 8'd7;
  localparam logic [VEC_W-1:0] VEC_PRIV      = 8'd8;
  localparam logic [VEC_W-1:0] VEC_TRACE     = 8'd9;
  localparam logic [VEC_W-1:0] VEC_LINE_A    = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F    = 8'd11;
  localparam logic [VEC_W-1:0] VEC_AUTO_BASE = 8'd24;
  localparam logic [VEC_W-1:0] VEC_TRAP_BASE = 8'd32;
endpackage

// File: rtl/exc_g0_sel.sv
module exc_g0_sel
  import exc_pkg::*;
(
  input  logic             rst_req_i,
  input  logic             bus_err_i,
  input  logic             addr_err_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    hit_o = 1'b1;
    if (rst_req_i)       vec_o = VEC_RESET;
    else if (bus_err_i)  vec_o = VEC_BUS_ERR;
    else if (addr_err_i) vec_o = VEC_ADDR_ERR;
    else begin
      hit_o = 1'b0;
      vec_o = '0;
    end
  end
endmodule

// File: rtl/exc_g1_sel.sv
module exc_g1_sel
  import exc_pkg::*;
#(
  parameter int IRQ_LVLS = 7,
  parameter int OPC_W    = 16
) (
  input  logic             trace_en_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             illegal_i,
  input  logic             priv_viol_i,
  input  logic             opcode_vld_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [3:0] NIB_A = 4'hA;
  localparam logic [3:0] NIB_F = 4'hF;

  logic [3:0] top_nib;
  logic       line_a, line_f;
  logic       irq_hit;
  logic [VEC_W-1:0] irq_vec;

  assign top_nib = opcode_i[OPC_W-1 -: 4];
  assign line_a  = opcode_vld_i && (top_nib == NIB_A);
  assign line_f  = opcode_vld_i && (top_nib == NIB_F);

  // ascending scan: the last match is the highest level
  always_comb begin
    irq_hit = 1'b0;
    irq_vec = '0;
    for (int l = 1; l <= IRQ_LVLS; l++) begin
      if (irq_lvl_i == LVL_W'(l)) begin
        irq_hit = 1'b1;
        irq_vec = VEC_AUTO_BASE + VEC_W'(l);
      end
    end
  end

  always_comb begin
    hit_o = 1'b1;
    if (trace_en_i)       vec_o = VEC_TRACE;
    else if (irq_hit)     vec_o = irq_vec;
    else if (illegal_i)   vec_o = VEC_ILLEGAL;
    else if (line_a)      vec_o = VEC_LINE_A;
    else if (line_f)      vec_o = VEC_LINE_F;
    else if (priv_viol_i) vec_o = VEC_PRIV;
    else begin
      hit_o = 1'b0;
      vec_o = '0;
    end
  end
endmodule

// File: rtl/exc_g2_sel.sv
module exc_g2_sel
  import exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     trap_i,
  input  logic [TRAP_W-1:0]        trap_num_i,
  input  logic                     trapv_i,
  input  logic                     v_flag_i,
  input  logic                     chk_i,
  input  logic signed [DATA_W-1:0] chk_val_i,
  input  logic signed [DATA_W-1:0] chk_bound_i,
  input  logic                     zdiv_i,
  output logic                     hit_o,
  output logic [VEC_W-1:0]         vec_o
);
  logic chk_fail;
  assign chk_fail = chk_i && ((chk_val_i < 0) || (chk_val_i > chk_bound_i));

  always_comb begin
    hit_o = 1'b1;
    if (trap_i)                   vec_o = VEC_TRAP_BASE + VEC_W'(trap_num_i);
    else if (trapv_i && v_flag_i) vec_o = VEC_TRAPV;
    else if (chk_fail)            vec_o = VEC_CHK;
    else if (zdiv_i)              vec_o = VEC_ZDIV;
    else begin
      hit_o = 1'b0;
      vec_o = '0;
    end
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IRQ_LVLS = 7,
  parameter int OPC_W    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rst_req_i,
  input  logic                     bus_err_i,
  input  logic                     addr_err_i,
  input  logic                     insn_done_i,
  input  logic                     trace_en_i,
  input  logic [LVL_W-1:0]         irq_lvl_i,
  input  logic                     illegal_i,
  input  logic                     priv_viol_i,
  input  logic                     opcode_vld_i,
  input  logic [OPC_W-1:0]         opcode_i,
  input  logic                     trap_i,
  input  logic [TRAP_W-1:0]        trap_num_i,
  input  logic                     trapv_i,
  input  logic                     v_flag_i,
  input  logic                     chk_i,
  input  logic signed [DATA_W-1:0] chk_val_i,
  input  logic signed [DATA_W-1:0] chk_bound_i,
  input  logic                     zdiv_i,
  output logic                     valid_o,
  output logic [VEC_W-1:0]         vector_o,
  output logic [1:0]               group_o,
  output logic                     abort_o
);
  logic             g0_hit, g1_hit, g2_hit;
  logic [VEC_W-1:0] g0_vec, g1_vec, g2_vec;
  logic             sel_vld;
  logic [VEC_W-1:0] sel_vec;
  exc_grp_e         sel_grp;

  exc_g0_sel u_g0 (
    .rst_req_i (rst_req_i),
    .bus_err_i (bus_err_i),
    .addr_err_i(addr_err_i),
    .hit_o     (g0_hit),
    .vec_o     (g0_vec)
  );

  exc_g1_sel #(.IRQ_LVLS(IRQ_LVLS), .OPC_W(OPC_W)) u_g1 (
    .trace_en_i  (trace_en_i),
    .irq_lvl_i   (irq_lvl_i),
    .illegal_i   (illegal_i),
    .priv_viol_i (priv_viol_i),
    .opcode_vld_i(opcode_vld_i),
    .opcode_i    (opcode_i),
    .hit_o       (g1_hit),
    .vec_o       (g1_vec)
  );

  exc_g2_sel #(.DATA_W(DATA_W)) u_g2 (
    .trap_i     (trap_i),
    .trap_num_i (trap_num_i),
    .trapv_i    (trapv_i),
    .v_flag_i   (v_flag_i),
    .chk_i      (chk_i),
    .chk_val_i  (chk_val_i),
    .chk_bound_i(chk_bound_i),
    .zdiv_i     (zdiv_i),
    .hit_o      (g2_hit),
    .vec_o      (g2_vec)
  );

  always_comb begin
    sel_vld = 1'b1;
    sel_grp = GRP_ABORT;
    sel_vec = '0;
    if (g0_hit) begin
      sel_vec = g0_vec;
    end else if (insn_done_i && g1_hit) begin
      sel_grp = GRP_BOUNDARY;
      sel_vec = g1_vec;
    end else if (g2_hit) begin
      sel_grp = GRP_INSN;
      sel_vec = g2_vec;
    end else begin
      sel_vld = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      vector_o <= '0;
      group_o  <= 2'd0;
      abort_o  <= 1'b0;
    end else begin
      valid_o  <= sel_vld;
      vector_o <= sel_vec;
      group_o  <= sel_grp;
      abort_o  <= sel_vld && (sel_grp == GRP_ABORT);
    end
  end

  p_abort_grp0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (valid_o && group_o == 2'd0));
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (vector_o == '0 && group_o == 2'd0 && !abort_o));
  p_bus_err_abort_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> (valid_o && abort_o));
  p_boundary_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && group_o == 2'd1) |-> $past(insn_done_i));
  p_trace_tbit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && group_o == 2'd1 && vector_o == VEC_TRACE) |-> $past(trace_en_i));
  p_trapv_vflag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && group_o == 2'd2 && vector_o == VEC_TRAPV) |-> $past(v_flag_i));
  p_group_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (group_o != 2'd3));
endmodule

// File: tb/tb_exc_arbiter.sv
module tb_exc_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rst_req, bus_err, addr_err, insn_done, trace_en;
  logic [2:0]  irq_lvl;
  logic        illegal, priv_viol, opcode_vld;
  logic [15:0] opcode;
  logic        trap;
  logic [3:0]  trap_num;
  logic        trapv, v_flag, chk;
  logic signed [31:0] chk_val, chk_bound;
  logic        zdiv;
  logic        valid;
  logic [7:0]  vector;
  logic [1:0]  group;
  logic        abort;

  exc_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .bus_err_i(bus_err),
    .addr_err_i(addr_err), .insn_done_i(insn_done), .trace_en_i(trace_en),
    .irq_lvl_i(irq_lvl), .illegal_i(illegal), .priv_viol_i(priv_viol),
    .opcode_vld_i(opcode_vld), .opcode_i(opcode), .trap_i(trap),
    .trap_num_i(trap_num), .trapv_i(trapv), .v_flag_i(v_flag), .chk_i(chk),
    .chk_val_i(chk_val), .chk_bound_i(chk_bound), .zdiv_i(zdiv),
    .valid_o(valid), .vector_o(vector), .group_o(group), .abort_o(abort)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic       e_valid, e_abort;
  logic [7:0] e_vec;
  logic [1:0] e_grp;
  string      e_tag;

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_in();
    rst_req = 0; bus_err = 0; addr_err = 0; insn_done = 0; trace_en = 0;
    irq_lvl = 0; illegal = 0; priv_viol = 0; opcode_vld = 0; opcode = 16'h4E71;
    trap = 0; trap_num = 0; trapv = 0; v_flag = 0; chk = 0;
    chk_val = 0; chk_bound = 0; zdiv = 0;
  endtask

  // behavioural model of the requirements
  task automatic model();
    int c1, c2;
    e_valid = 1; e_abort = 0; e_grp = 0; e_vec = 0; e_tag = "R9";
    c1 = -1; c2 = -1;
    if (insn_done) begin
      if (trace_en) c1 = 9;
      else if (irq_lvl != 0) c1 = 24 + int'(irq_lvl);
      else if (illegal) c1 = 4;
      else if (opcode_vld && opcode[15:12] == 4'hA) c1 = 10;
      else if (opcode_vld && opcode[15:12] == 4'hF) c1 = 11;
      else if (priv_viol) c1 = 8;
    end
    if (trap) c2 = 32 + int'(trap_num);
    else if (trapv && v_flag) c2 = 7;
    else if (chk && (chk_val < 0 || chk_val > chk_bound)) c2 = 6;
    else if (zdiv) c2 = 5;
    if (rst_req || bus_err || addr_err) begin
      e_abort = 1; e_tag = "R1";
      e_vec = rst_req ? 8'd0 : bus_err ? 8'd2 : 8'd3;
    end else if (c1 >= 0) begin
      e_grp = 1; e_vec = 8'(c1); e_tag = "R2";
    end else if (c2 >= 0) begin
      e_grp = 2; e_vec = 8'(c2); e_tag = "R5";
    end else begin
      e_valid = 0;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (valid !== e_valid || vector !== e_vec || group !== e_grp || abort !== e_abort) begin
      failures++;
      $display("FAIL %s/%s: actual v=%0b vec=%0d grp=%0d ab=%0b expected v=%0b vec=%0d grp=%0d ab=%0b",
               tag, e_tag, valid, vector, group, abort, e_valid, e_vec, e_grp, e_abort);
    end
  endtask

  // inputs already set at a falling edge; result due one clock later
  task automatic step(string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    // R10: outputs held at zero in reset
    e_valid = 0; e_vec = 0; e_grp = 0; e_abort = 0; e_tag = "R10";
    rst_req = 1; bus_err = 1;
    compare("R10");
    clear_in();
    @(negedge clk);
    rst_n = 1;
    step("R9_idle");

    // R1 order inside abort class, no boundary needed
    rst_req = 1; bus_err = 1; addr_err = 1; step("R1_reset");
    clear_in(); bus_err = 1; addr_err = 1; step("R1_bus");
    clear_in(); addr_err = 1; trap = 1; step("R1_addr_R8");
    // R8 abort over boundary class
    clear_in(); addr_err = 1; insn_done = 1; trace_en = 1; step("R8_g0_over_g1");
    // R2 boundary gating
    clear_in(); trace_en = 1; irq_lvl = 7; illegal = 1; step("R2_no_boundary");
    insn_done = 1; step("R3_trace");
    trace_en = 0; step("R2_irq7");
    irq_lvl = 1; step("R2_irq1");
    irq_lvl = 0; priv_viol = 1; step("R2_illegal_over_priv");
    illegal = 0; opcode_vld = 1; opcode = 16'hA123; step("R4_lineA");
    opcode = 16'hF000; step("R4_lineF");
    opcode = 16'hB000; step("R4_other_priv");
    opcode_vld = 0; opcode = 16'hA000; priv_viol = 0; step("R4_not_valid");
    // R8 boundary over instruction class
    clear_in(); insn_done = 1; irq_lvl = 3; trap = 1; trap_num = 4'd15; step("R8_g1_over_g2");
    // R5 order inside instruction class
    clear_in(); trap = 1; trap_num = 4'd15; trapv = 1; v_flag = 1; step("R5_trap15");
    trap_num = 4'd0; step("R5_trap0");
    trap = 0; chk = 1; chk_val = -1; step("R5_trapv");
    v_flag = 0; step("R6_trapv_no_v_chk");
    chk = 0; zdiv = 1; step("R6_ignored_zdiv");
    // R7 bounds
    clear_in(); chk = 1; chk_bound = 100; chk_val = 100; step("R7_equal_bound");
    chk_val = 101; step("R7_above");
    chk_val = 0; step("R7_zero");
    chk_val = -2147483647 - 1; step("R7_most_neg");
    chk_bound = -5; chk_val = 3; step("R7_neg_bound");
    clear_in(); step("R9_idle_again");

    // mixed patterns, every clock compared
    for (int i = 0; i < 400; i++) begin
      clear_in();
      rst_req    = ($urandom_range(0, 40) == 0);
      bus_err    = ($urandom_range(0, 20) == 0);
      addr_err   = ($urandom_range(0, 20) == 0);
      insn_done  = ($urandom_range(0, 1) == 0);
      trace_en   = ($urandom_range(0, 6) == 0);
      irq_lvl    = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      illegal    = ($urandom_range(0, 5) == 0);
      priv_viol  = ($urandom_range(0, 4) == 0);
      opcode_vld = ($urandom_range(0, 1) == 0);
      opcode     = 16'($urandom);
      trap       = ($urandom_range(0, 5) == 0);
      trap_num   = 4'($urandom_range(0, 15));
      trapv      = ($urandom_range(0, 3) == 0);
      v_flag     = ($urandom_range(0, 1) == 0);
      chk        = ($urandom_range(0, 2) == 0);
      chk_val    = $signed(32'($urandom_range(0, 40))) - 10;
      chk_bound  = $signed(32'($urandom_range(0, 20)));
      zdiv       = ($urandom_range(0, 3) == 0);
      step("R9_mixed");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule